// File: doc/BRIEF.md
# Cartridge PRG Bank Mapper

This block sits between the console CPU bus and the program ROM of a cartridge. It maps the CPU range $6000-$FFFF onto a 128 KiB ROM image through five 8 KiB windows. Four of the windows are fixed. The fifth, at $C000-$DFFF, follows a small select register that the CPU writes at $4022.

The select register holds a 3-bit value. That value is not used as the bank number directly. Each even value chooses one of banks 4 to 7, and every odd value chooses bank 3.

The top window comes from a 2 KiB device that repeats four times across the 8 KiB range. Pattern-table accesses pass through to an unbanked 8 KiB CHR region.

Top module: `prg_bank_mapper`

## Requirements
- R1: A CPU access in $6000-$7FFF gives rom_addr = {4'd2, cpu_addr[12:0]}.
- R2: $8000-$9FFF gives rom_addr = {4'd1, cpu_addr[12:0]}, and $A000-$BFFF gives rom_addr = {4'd0, cpu_addr[12:0]}.
- R3: $C000-$DFFF gives rom_addr = {bank, cpu_addr[12:0]}, where bank is the translated value of the select register.
- R4: The translation maps select 0 to bank 4, 2 to bank 5, 4 to bank 6 and 6 to bank 7, and maps every odd select (1, 3, 5, 7) to bank 3.
- R5: $E000-$FFFF gives rom_addr = {4'd8, 2'b00, cpu_addr[10:0]}, so address bits 12:11 do not change the ROM address.
- R6: A CPU write with m2 high, cpu_rw low and (cpu_addr & 16'hF1FF) == 16'h4022 stores cpu_data[2:0] at the rising clock edge. CPU address bits 11:9 and data bits 7:3 have no effect on the stored value.
- R7: The select register does not change on a write to any other address, on a read at $4022, or on a write to $4022 while m2 is low.
- R8: After reset the select register is 0, so the $C000 window maps to bank 4.
- R9: rom_ce is high only when cpu_rw is high and cpu_addr is at or above $6000. It is low for writes and for lower addresses, and rom_addr is 0 whenever rom_ce is low.
- R10: chr_addr equals ppu_addr[12:0], and chr_ce is high only when ppu_addr[13] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| m2 | input | 1 | CPU bus phase; a write counts only while it is high |
| ppu_addr | input | 14 | PPU address bus |
| rom_addr | output | 17 | Physical PRG-ROM address |
| rom_ce | output | 1 | PRG-ROM chip enable |
| chr_addr | output | 13 | CHR-ROM address |
| chr_ce | output | 1 | CHR-ROM chip enable |

## Verification
Several properties are checked on every cycle:
- The select register holds its value unless a qualified write occurs.
- A qualified write stores exactly the low three data bits.
- The chip enable never rises on a write.
- Every odd select maps the $C000 window to bank 3.
- The top window always lands in bank 8 with address bits 12:11 cleared.

Other behaviour can only be shown by the bench's scenarios:
- The full even-value translation table.
- Which aliases of $4022 are accepted.
- How reads and low-m2 writes are rejected.
- The reset value.
- The fixed-window offsets.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int SEL_W   = 3;
    localparam int BANK_W  = 4;
    localparam int WIN_W   = 13;
    localparam int ROM_AW  = BANK_W + WIN_W;
    localparam int MIRR_W  = 11;
    localparam int PPU_W   = 14;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } sel_state_t;

    // Even selects step through banks 4..7; odd selects all land on bank 3.
    function automatic logic [BANK_W-1:0] xlate_sel(input logic [SEL_W-1:0] s);
        if (s[0]) begin
            return BANK_W'(3);
        end
        return BANK_W'(4) + BANK_W'(s[SEL_W-1:1]);
    endfunction
endpackage

// File: rtl/sel_register.sv
module sel_register
    import prg_map_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [SEL_W-1:0] wr_val,
    output logic [SEL_W-1:0] sel_out
);
    sel_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.sel = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_out = st_q.sel;

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(sel_out)) else $error("select changed without write"); // R7
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> sel_out == $past(wr_val)) else $error("select load wrong"); // R6
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
    import prg_map_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic [SEL_W-1:0]  sel,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_ce
);
    localparam int MIRR_PAD = WIN_W - MIRR_W;

    logic [2:0]        win;
    logic [BANK_W-1:0] bank;
    logic [WIN_W-1:0]  offs;
    logic              in_rom;

    assign win = cpu_addr[ADDR_W-1:WIN_W];

    always_comb begin
        bank   = '0;
        offs   = cpu_addr[WIN_W-1:0];
        in_rom = 1'b1;
        unique case (win)
            3'd3: bank = BANK_W'(2);
            3'd4: bank = BANK_W'(1);
            3'd5: bank = BANK_W'(0);
            3'd6: bank = xlate_sel(sel);
            3'd7: begin
                bank = BANK_W'(8);
                offs = {{MIRR_PAD{1'b0}}, cpu_addr[MIRR_W-1:0]};
            end
            default: in_rom = 1'b0;
        endcase
    end

    assign rom_ce   = in_rom && cpu_rw;
    assign rom_addr = rom_ce ? {bank, offs} : '0;
endmodule

// File: rtl/chr_passthru.sv
module chr_passthru
    import prg_map_pkg::*;
(
    input  logic [PPU_W-1:0]   ppu_addr,
    output logic [WIN_W-1:0]   chr_addr,
    output logic               chr_ce
);
    assign chr_addr = ppu_addr[WIN_W-1:0];
    assign chr_ce   = ~ppu_addr[PPU_W-1];
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_rw,
    input  logic              m2,
    input  logic [13:0]       ppu_addr,
    output logic [16:0]       rom_addr,
    output logic              rom_ce,
    output logic [12:0]       chr_addr,
    output logic              chr_ce
);
    localparam logic [ADDR_W-1:0] SEL_MASK = 16'hF1FF;
    localparam logic [ADDR_W-1:0] SEL_PORT = 16'h4022;

    logic             wr_hit;
    logic [SEL_W-1:0] sel_q;
    logic             unused_data_hi;

    assign wr_hit         = m2 && !cpu_rw && ((cpu_addr & SEL_MASK) == SEL_PORT);
    assign unused_data_hi = ^cpu_data[DATA_W-1:SEL_W];

    sel_register i_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_val  (cpu_data[SEL_W-1:0]),
        .sel_out (sel_q)
    );

    prg_window_decode i_dec (
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .sel      (sel_q),
        .rom_addr (rom_addr),
        .rom_ce   (rom_ce)
    );

    chr_passthru i_chr (
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr),
        .chr_ce   (chr_ce)
    );

    AST_CE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce |-> cpu_rw) else $error("rom_ce on write"); // R9
    AST_ODD_BANK3: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_ce && cpu_addr[15:13] == 3'd6 && sel_q[0]) |-> rom_addr[16:13] == 4'd3)
        else $error("odd select not bank 3"); // R4
    AST_TOP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_ce && cpu_addr[15:13] == 3'd7) |-> (rom_addr[16:13] == 4'd8 && rom_addr[12:11] == 2'b00))
        else $error("top window not mirrored"); // R5
endmodule

// File: tb/test_prg_bank_mapper.sv
module test_prg_bank_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rw = 1'b1;
    logic        m2 = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [16:0] rom_addr;
    logic        rom_ce;
    logic [12:0] chr_addr;
    logic        chr_ce;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prg_bank_mapper i_prg_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .m2(m2), .ppu_addr(ppu_addr), .rom_addr(rom_addr),
        .rom_ce(rom_ce), .chr_addr(chr_addr), .chr_ce(chr_ce)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] bank_of(input logic [2:0] s);
        if (s[0]) return 4'd3;
        return 4'd4 + {2'b00, s[2:1]};
    endfunction

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic m2v);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = 1'b0; m2 = m2v;
        @(negedge clk);
        cpu_rw = 1'b1; m2 = 1'b0; cpu_addr = 16'h0000;
    endtask

    task automatic read_at(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rw = 1'b1;
        #1;
    endtask

    task automatic t_reset;
        read_at(16'hC123);
        chk(rom_addr, {4'd4, 13'h0123}, "R8");
        chk(rom_ce, 1, "R8");
    endtask

    task automatic t_fixed;
        read_at(16'h6ABC); chk(rom_addr, {4'd2, 13'h0ABC}, "R1");
        read_at(16'h7FFF); chk(rom_addr, {4'd2, 13'h1FFF}, "R1");
        read_at(16'h8001); chk(rom_addr, {4'd1, 13'h0001}, "R2");
        read_at(16'hBFFE); chk(rom_addr, {4'd0, 13'h1FFE}, "R2");
    endtask

    task automatic t_switch;
        for (int v = 0; v < 8; v++) begin
            cpu_write(16'h4022, {5'b10101, v[2:0]}, 1'b1);
            read_at(16'hD5A5);
            chk(rom_addr, {bank_of(v[2:0]), 13'h15A5}, "R3/R4");
        end
    endtask

    task automatic t_alias;
        cpu_write(16'h4E22, 8'h02, 1'b1);
        read_at(16'hC000); chk(rom_addr, {4'd5, 13'h0}, "R6 alias");
        cpu_write(16'h4222, 8'hFC, 1'b1);
        read_at(16'hC000); chk(rom_addr, {4'd6, 13'h0}, "R6 data mask");
    endtask

    task automatic t_ignored;
        cpu_write(16'h4022, 8'h06, 1'b1);
        cpu_write(16'h4122, 8'h01, 1'b1);
        read_at(16'hC010); chk(rom_addr, {4'd7, 13'h10}, "R7 other addr");
        cpu_write(16'h4022, 8'h01, 1'b0);
        read_at(16'hC010); chk(rom_addr, {4'd7, 13'h10}, "R7 m2 low");
        @(negedge clk); cpu_addr = 16'h4022; cpu_rw = 1'b1; m2 = 1'b1; cpu_data = 8'h01;
        @(negedge clk); m2 = 1'b0;
        read_at(16'hC010); chk(rom_addr, {4'd7, 13'h10}, "R7 read");
    endtask

    task automatic t_mirror;
        read_at(16'hE123); chk(rom_addr, {4'd8, 2'b00, 11'h123}, "R5");
        read_at(16'hF923); chk(rom_addr, {4'd8, 2'b00, 11'h123}, "R5 alias");
    endtask

    task automatic t_ce;
        read_at(16'h5FFF); chk({rom_ce, rom_addr}, 18'h0, "R9 low addr");
        @(negedge clk); cpu_addr = 16'h8000; cpu_rw = 1'b0; #1;
        chk({rom_ce, rom_addr}, 18'h0, "R9 write");
        cpu_rw = 1'b1; #1;
        chk(rom_ce, 1, "R9 read");
    endtask

    task automatic t_chr;
        ppu_addr = 14'h1ABC; #1;
        chk({chr_ce, chr_addr}, {1'b1, 13'h1ABC}, "R10");
        ppu_addr = 14'h2ABC; #1;
        chk(chr_ce, 0, "R10 nametable");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_switch();
        t_alias();
        t_ignored();
        t_mirror();
        t_ce();
        t_chr();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule